// File: doc/BRIEF.md
# Packet Transfer Handshake Controller

This block moves whole packets, one at a time, between a local scheduler and a word-wide packet queue. It works in both directions. The fill side takes a packet from the scheduler and writes it into a queue. The drain side reads packets out of a queue and hands them to the scheduler. Every transfer is a request/acknowledge exchange. The requesting side presents the packet length together with its request. The answering side raises the acknowledge only when the queue descriptor shows that the whole packet can move without stalling.

Each packet stored in a queue starts with one 32-bit header word, followed by the payload words. The header carries the byte length and the count of valid bytes in the final word. Space is claimed or released in the queue descriptor by a single commit pulse, issued once the last word has moved. The controller then waits for the handshake to be taken down before it accepts the next packet.

Top module: `pkt_xfer_ctrl`

## Requirements
- R1: Fill side. A request is latched together with its length. `fl_ack_o` rises only when `fl_q_free_i` is at least ceil(len/4)+1 words, and it stays low for as long as the free space is smaller. When the space is sufficient, the header is written one cycle after the request is sampled, and `fl_ack_o` is high the cycle after that.
- R2: Fill side. The first word written to the queue is the header: bits [15:0] hold the byte length, bits [17:16] hold len mod 4 (the valid-byte count of the last word, where 0 means all four bytes), and bits [31:18] are zero.
- R3: Fill side. Payload words are written in arrival order, one for each cycle in which `fl_valid_i` is high while the acknowledge is up, ceil(len/4) words in all. In the last word, byte k occupies bits [8k+7:8k], and every byte at or above the valid count is written as zero.
- R4: Fill side. One cycle after the last payload word, `fl_q_commit_o` pulses for exactly one cycle, with no queue write in that cycle. `fl_q_commit_words_o` then equals the total word count including the header.
- R5: Fill side. `fl_ack_o` stays high after the commit until the request is withdrawn, and it is low by the second cycle after the withdrawal.
- R6: A fill request of length zero is acknowledged. The controller writes its header alone and commits one word.
- R7: Drain side. While `dr_q_used_i` is nonzero, the header at the queue head is popped. `dr_req_o` is then raised, with `dr_len_o` set to header bits [15:0] and `dr_tail_o` set to header bits [17:16]. The request is raised only once `dr_q_used_i` covers the header plus ceil(len/4) payload words.
- R8: Drain side. After `dr_ack_i`, the payload words leave on `dr_data_o` at one word per cycle, each with `dr_valid_o` high. The last word carries `dr_last_o`, and the header word never appears on the data output.
- R9: Drain side. After the last payload word, `dr_q_commit_o` pulses for one cycle with the total word count. `dr_req_o` is low in the next cycle, and the controller returns to idle once `dr_ack_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fl_req_i | input | 1 | Fill request from the scheduler |
| fl_len_i | input | 16 | Fill packet length in bytes, valid with the request |
| fl_ack_o | output | 1 | Fill acknowledge |
| fl_valid_i | input | 1 | Fill payload word strobe |
| fl_data_i | input | 32 | Fill payload word |
| fl_q_free_i | input | CNT_W | Free words from the fill queue descriptor |
| fl_q_wr_o | output | 1 | Fill queue write strobe |
| fl_q_wdata_o | output | 32 | Fill queue write word |
| fl_q_commit_o | output | 1 | Fill descriptor commit pulse |
| fl_q_commit_words_o | output | CNT_W | Words claimed by the fill commit |
| dr_q_used_i | input | CNT_W | Committed words from the drain queue descriptor |
| dr_q_rdata_i | input | 32 | Word at the drain queue head (show-ahead) |
| dr_q_rd_o | output | 1 | Drain queue pop strobe |
| dr_q_commit_o | output | 1 | Drain descriptor commit pulse |
| dr_q_commit_words_o | output | CNT_W | Words released by the drain commit |
| dr_req_o | output | 1 | Drain request to the scheduler |
| dr_len_o | output | 16 | Drain packet length in bytes |
| dr_tail_o | output | 2 | Valid bytes in the last drain word, 0 meaning 4 |
| dr_ack_i | input | 1 | Drain acknowledge from the scheduler |
| dr_valid_o | output | 1 | Drain payload word strobe |
| dr_data_o | output | 32 | Drain payload word |
| dr_last_o | output | 1 | Marks the last drain payload word |

## Verification
When the fill side has room, the header is on the write port in the cycle after the request is sampled. The acknowledge follows one cycle later. Each payload word is written in the same cycle it is presented, and the commit comes in the cycle after the last word. On the drain side, the request appears two cycles after committed data arrives, and each payload word is visible in the cycle after the acknowledge edge that opens it. The bench drives inputs on falling edges, and its monitors compare queue writes, commits and drain words at every falling edge against scoreboard queues filled by the driver. The checks therefore land in exactly the cycle each result is due, and an early, late or missing result shows up as a mismatch or a leftover entry.

// File: rtl/pkt_xfer_pkg.sv
package pkt_xfer_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LEN_W  = 16;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SPACE,
    ST_ACK,
    ST_XFER,
    ST_COMMIT,
    ST_DONE
  } xfer_st_e;

  function automatic len_t pay_words(input len_t len);
    return (len >> 2) + len_t'(len[1:0] != 2'b00);
  endfunction

  // [15:0] length, [17:16] valid bytes of last word (0 = all four)
  function automatic word_t make_hdr(input len_t len);
    return {{(WORD_W-LEN_W-2){1'b0}}, len[1:0], len};
  endfunction

  function automatic word_t tail_mask(input len_t len);
    case (len[1:0])
      2'd1:    return word_t'(32'h0000_00ff);
      2'd2:    return word_t'(32'h0000_ffff);
      2'd3:    return word_t'(32'h00ff_ffff);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/pxf_space_gate.sv
module pxf_space_gate
  import pkt_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  len_t             len_i,
  input  logic [CNT_W-1:0] avail_i,
  output len_t             pay_o,
  output len_t             need_o,
  output logic             fits_o
);
  assign pay_o  = pay_words(len_i);
  assign need_o = pay_o + len_t'(1);
  assign fits_o = 32'(avail_i) >= 32'(need_o);
endmodule

// File: rtl/pxf_fill_eng.sv
module pxf_fill_eng
  import pkt_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  len_t             len_i,
  output logic             ack_o,
  input  logic             valid_i,
  input  word_t            data_i,
  input  logic [CNT_W-1:0] q_free_i,
  output logic             q_wr_o,
  output word_t            q_wdata_o,
  output logic             q_commit_o,
  output logic [CNT_W-1:0] q_commit_words_o
);
  xfer_st_e st_q, st_d;
  len_t     len_q, cnt_q, cnt_d;
  len_t     pay, need;
  logic     fits, last_word;

  pxf_space_gate #(.CNT_W(CNT_W)) u_gate (
    .len_i  (len_q),
    .avail_i(q_free_i),
    .pay_o  (pay),
    .need_o (need),
    .fits_o (fits)
  );

  assign last_word        = (cnt_q + len_t'(1)) == pay;
  assign q_commit_words_o = CNT_W'(need);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    ack_o      = 1'b0;
    q_wr_o     = 1'b0;
    q_wdata_o  = '0;
    q_commit_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_WAIT_SPACE;
      ST_WAIT_SPACE: begin
        if (fits) begin
          q_wr_o    = 1'b1;
          q_wdata_o = make_hdr(len_q);
          cnt_d     = '0;
          st_d      = ST_ACK;
        end
      end
      ST_ACK, ST_XFER: begin
        ack_o = 1'b1;
        if (pay == '0) begin
          st_d = ST_COMMIT;
        end else if (valid_i) begin
          q_wr_o    = 1'b1;
          q_wdata_o = last_word ? (data_i & tail_mask(len_q)) : data_i;
          cnt_d     = cnt_q + len_t'(1);
          st_d      = last_word ? ST_COMMIT : ST_XFER;
        end
      end
      ST_COMMIT: begin
        ack_o      = 1'b1;
        q_commit_o = 1'b1;
        st_d       = ST_DONE;
      end
      ST_DONE: begin
        ack_o = 1'b1;
        if (!req_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (st_q == ST_IDLE && req_i) len_q <= len_i;
    end
  end
endmodule

// File: rtl/pxf_drain_eng.sv
module pxf_drain_eng
  import pkt_xfer_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] q_used_i,
  input  word_t            q_rdata_i,
  output logic             q_rd_o,
  output logic             q_commit_o,
  output logic [CNT_W-1:0] q_commit_words_o,
  output logic             req_o,
  output len_t             len_o,
  output logic [1:0]       tail_o,
  input  logic             ack_i,
  output logic             valid_o,
  output word_t            data_o,
  output logic             last_o
);
  xfer_st_e   st_q, st_d;
  len_t       len_q, cnt_q, cnt_d;
  logic [1:0] tail_q;
  len_t       pay, need;
  logic       fits, last_word, head_avail;
  logic       unused_hdr_hi;

  pxf_space_gate #(.CNT_W(CNT_W)) u_gate (
    .len_i  (len_q),
    .avail_i(q_used_i),
    .pay_o  (pay),
    .need_o (need),
    .fits_o (fits)
  );

  assign head_avail       = q_used_i != '0;
  assign last_word        = (cnt_q + len_t'(1)) == pay;
  assign q_commit_words_o = CNT_W'(need);
  assign len_o            = len_q;
  assign tail_o           = tail_q;
  assign unused_hdr_hi    = ^q_rdata_i[WORD_W-1:LEN_W+2];

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    q_rd_o     = 1'b0;
    q_commit_o = 1'b0;
    req_o      = 1'b0;
    valid_o    = 1'b0;
    data_o     = '0;
    last_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (head_avail) begin
          q_rd_o = 1'b1;
          st_d   = ST_WAIT_SPACE;
        end
      end
      ST_WAIT_SPACE: if (fits) st_d = ST_ACK;
      ST_ACK: begin
        req_o = 1'b1;
        cnt_d = '0;
        if (ack_i) st_d = (pay == '0) ? ST_COMMIT : ST_XFER;
      end
      ST_XFER: begin
        req_o   = 1'b1;
        valid_o = 1'b1;
        data_o  = q_rdata_i;
        last_o  = last_word;
        q_rd_o  = 1'b1;
        cnt_d   = cnt_q + len_t'(1);
        if (last_word) st_d = ST_COMMIT;
      end
      ST_COMMIT: begin
        req_o      = 1'b1;
        q_commit_o = 1'b1;
        st_d       = ST_DONE;
      end
      ST_DONE: if (!ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (st_q == ST_IDLE && head_avail) begin
        len_q  <= q_rdata_i[LEN_W-1:0];
        tail_q <= q_rdata_i[LEN_W+1:LEN_W];
      end
    end
  end
endmodule

// File: rtl/pkt_xfer_ctrl.sv
module pkt_xfer_ctrl
  import pkt_xfer_pkg::*;
#(
  parameter  int unsigned Q_DEPTH = 512,
  localparam int unsigned CNT_W   = $clog2(Q_DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fl_req_i,
  input  logic [15:0]      fl_len_i,
  output logic             fl_ack_o,
  input  logic             fl_valid_i,
  input  logic [31:0]      fl_data_i,
  input  logic [CNT_W-1:0] fl_q_free_i,
  output logic             fl_q_wr_o,
  output logic [31:0]      fl_q_wdata_o,
  output logic             fl_q_commit_o,
  output logic [CNT_W-1:0] fl_q_commit_words_o,
  input  logic [CNT_W-1:0] dr_q_used_i,
  input  logic [31:0]      dr_q_rdata_i,
  output logic             dr_q_rd_o,
  output logic             dr_q_commit_o,
  output logic [CNT_W-1:0] dr_q_commit_words_o,
  output logic             dr_req_o,
  output logic [15:0]      dr_len_o,
  output logic [1:0]       dr_tail_o,
  input  logic             dr_ack_i,
  output logic             dr_valid_o,
  output logic [31:0]      dr_data_o,
  output logic             dr_last_o
);
  pxf_fill_eng #(.CNT_W(CNT_W)) u_fill (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_i           (fl_req_i),
    .len_i           (fl_len_i),
    .ack_o           (fl_ack_o),
    .valid_i         (fl_valid_i),
    .data_i          (fl_data_i),
    .q_free_i        (fl_q_free_i),
    .q_wr_o          (fl_q_wr_o),
    .q_wdata_o       (fl_q_wdata_o),
    .q_commit_o      (fl_q_commit_o),
    .q_commit_words_o(fl_q_commit_words_o)
  );

  pxf_drain_eng #(.CNT_W(CNT_W)) u_drain (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .q_used_i        (dr_q_used_i),
    .q_rdata_i       (dr_q_rdata_i),
    .q_rd_o          (dr_q_rd_o),
    .q_commit_o      (dr_q_commit_o),
    .q_commit_words_o(dr_q_commit_words_o),
    .req_o           (dr_req_o),
    .len_o           (dr_len_o),
    .tail_o          (dr_tail_o),
    .ack_i           (dr_ack_i),
    .valid_o         (dr_valid_o),
    .data_o          (dr_data_o),
    .last_o          (dr_last_o)
  );
endmodule

// File: rtl/pkt_xfer_ctrl_chk.sv
module pkt_xfer_ctrl_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fl_req_i,
  input logic             fl_ack_o,
  input logic             fl_valid_i,
  input logic [CNT_W-1:0] fl_q_free_i,
  input logic             fl_q_wr_o,
  input logic             fl_q_commit_o,
  input logic [CNT_W-1:0] dr_q_used_i,
  input logic             dr_q_commit_o,
  input logic             dr_req_o,
  input logic             dr_ack_i,
  input logic             dr_valid_o
);
  a_r1_hdr_needs_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_q_wr_o && !fl_ack_o) |-> (fl_q_free_i != '0));

  a_r3_write_under_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_q_wr_o && fl_ack_o) |-> fl_valid_i);

  a_r4_no_write_at_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_q_commit_o |-> !fl_q_wr_o);

  a_r4_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_q_commit_o |=> !fl_q_commit_o);

  a_r5_ack_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_ack_o && !fl_req_i && !fl_q_commit_o) |=> !fl_ack_o);

  a_r7_req_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_req_o |-> (dr_q_used_i != '0));

  a_r8_valid_under_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_valid_o |-> (dr_req_o && dr_ack_i));

  a_r9_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_q_commit_o |=> !dr_req_o);
endmodule

bind pkt_xfer_ctrl pkt_xfer_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fl_req_i     (fl_req_i),
  .fl_ack_o     (fl_ack_o),
  .fl_valid_i   (fl_valid_i),
  .fl_q_free_i  (fl_q_free_i),
  .fl_q_wr_o    (fl_q_wr_o),
  .fl_q_commit_o(fl_q_commit_o),
  .dr_q_used_i  (dr_q_used_i),
  .dr_q_commit_o(dr_q_commit_o),
  .dr_req_o     (dr_req_o),
  .dr_ack_i     (dr_ack_i),
  .dr_valid_o   (dr_valid_o)
);

// File: tb/pkt_xfer_ctrl_tb_top.sv
module pkt_xfer_ctrl_tb_top;
  localparam int unsigned QD    = 16;
  localparam int unsigned CNT_W = $clog2(QD) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             fl_req = 1'b0, fl_valid = 1'b0;
  logic [15:0]      fl_len = '0;
  logic [31:0]      fl_data = '0;
  logic             fl_ack, fl_q_wr, fl_q_commit;
  logic [31:0]      fl_q_wdata;
  logic [CNT_W-1:0] fl_q_free, fl_q_commit_words;
  logic [CNT_W-1:0] dr_q_used, dr_q_commit_words;
  logic [31:0]      dr_q_rdata, dr_data;
  logic             dr_q_rd, dr_q_commit, dr_req, dr_valid, dr_last;
  logic             dr_ack = 1'b0;
  logic [15:0]      dr_len;
  logic [1:0]       dr_tail;

  pkt_xfer_ctrl #(.Q_DEPTH(QD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fl_req_i(fl_req), .fl_len_i(fl_len), .fl_ack_o(fl_ack),
    .fl_valid_i(fl_valid), .fl_data_i(fl_data), .fl_q_free_i(fl_q_free),
    .fl_q_wr_o(fl_q_wr), .fl_q_wdata_o(fl_q_wdata),
    .fl_q_commit_o(fl_q_commit), .fl_q_commit_words_o(fl_q_commit_words),
    .dr_q_used_i(dr_q_used), .dr_q_rdata_i(dr_q_rdata), .dr_q_rd_o(dr_q_rd),
    .dr_q_commit_o(dr_q_commit), .dr_q_commit_words_o(dr_q_commit_words),
    .dr_req_o(dr_req), .dr_len_o(dr_len), .dr_tail_o(dr_tail),
    .dr_ack_i(dr_ack), .dr_valid_o(dr_valid), .dr_data_o(dr_data),
    .dr_last_o(dr_last)
  );

  // queue model shared by both sides: fill writes it, drain reads it
  logic [31:0] mem [QD];
  int          wp, rp, occ;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= 0; rp <= 0; occ <= 0;
    end else begin
      if (fl_q_wr) begin
        mem[wp] <= fl_q_wdata;
        wp      <= (wp + 1) % QD;
      end
      if (dr_q_rd) rp <= (rp + 1) % QD;
      occ <= occ + (fl_q_commit ? int'(fl_q_commit_words) : 0)
                 - (dr_q_commit ? int'(dr_q_commit_words) : 0);
    end
  end
  assign fl_q_free  = CNT_W'(QD - occ);
  assign dr_q_used  = CNT_W'(occ);
  assign dr_q_rdata = mem[rp];

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboards
  logic [31:0] exp_wr[$];
  string       exp_wr_tag[$];
  int          exp_fc[$];
  string       exp_fc_tag[$];
  int          exp_dlen[$];
  logic [31:0] exp_ddata[$];

  function automatic logic [31:0] mask_for(input int len);
    case (len % 4)
      1: return 32'h0000_00ff;
      2: return 32'h0000_ffff;
      3: return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  task automatic send_pkt(input int len, input bit gaps);
    int pw;
    logic [31:0] raw, m;
    pw = (len + 3) / 4;
    exp_wr.push_back({14'd0, 2'(len % 4), 16'(len)});
    exp_wr_tag.push_back("R2");
    for (int k = 0; k < pw; k++) begin
      raw = {8'(len), 8'(k), 8'hc3, 8'(k * 7 + 1)} | 32'h8000_0000;
      m   = (k == pw - 1) ? (raw & mask_for(len)) : raw;
      exp_wr.push_back(m);
      exp_wr_tag.push_back("R3");
      exp_ddata.push_back(m);
    end
    exp_fc.push_back(pw + 1);
    exp_fc_tag.push_back(len == 0 ? "R6" : "R4");
    exp_dlen.push_back(len);
    @(negedge clk);
    fl_req = 1'b1;
    fl_len = 16'(len);
    while (!fl_ack) @(negedge clk);
    for (int k = 0; k < pw; k++) begin
      if (gaps && (k % 2 == 1)) begin
        fl_valid = 1'b0;
        @(negedge clk);
      end
      fl_valid = 1'b1;
      fl_data  = {8'(len), 8'(k), 8'hc3, 8'(k * 7 + 1)} | 32'h8000_0000;
      @(negedge clk);
    end
    fl_valid = 1'b0;
    fl_data  = '0;
    while (!fl_q_commit) @(negedge clk);
    fl_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!fl_ack, "R5 ack released", 32'(fl_ack), 0);
  endtask

  // fill monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_q_wr) begin
        if (exp_wr.size() == 0) chk(0, "R3 unexpected write", fl_q_wdata, 0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_wr.pop_front();
          t = exp_wr_tag.pop_front();
          chk(fl_q_wdata == e, {t, " queue word"}, fl_q_wdata, e);
        end
      end
      if (fl_q_commit) begin
        if (exp_fc.size() == 0) chk(0, "R4 unexpected commit", 32'(fl_q_commit_words), 0);
        else begin
          int e;
          string t;
          e = exp_fc.pop_front();
          t = exp_fc_tag.pop_front();
          chk(int'(fl_q_commit_words) == e, {t, " commit words"}, 32'(fl_q_commit_words), 32'(e));
          chk(!fl_q_wr, "R4 no write at commit", 32'(fl_q_wr), 0);
        end
      end
    end
  end

  // drain sink
  bit sink_en = 1'b0;
  initial begin
    bit in_pkt = 0, chk_drop = 0;
    int cnt = 0, pw = 0, dl = 0;
    forever begin
      @(negedge clk);
      if (chk_drop) begin
        chk(!dr_req, "R9 request withdrawn", 32'(dr_req), 0);
        chk_drop = 0;
      end
      if (!in_pkt) begin
        if (sink_en && dr_req && !dr_ack) begin
          dl = (exp_dlen.size() != 0) ? exp_dlen.pop_front() : -1;
          pw = (dl + 3) / 4;
          chk(int'(dr_len) == dl, "R7 drain length", 32'(dr_len), 32'(dl));
          chk(int'(dr_tail) == dl % 4, "R7 drain tail", 32'(dr_tail), 32'(dl % 4));
          cnt = 0; in_pkt = 1; dr_ack = 1'b1;
        end
      end else begin
        if (dr_valid) begin
          logic [31:0] e;
          e = (exp_ddata.size() != 0) ? exp_ddata.pop_front() : 32'hdead_beef;
          chk(dr_data == e, "R8 drain word", dr_data, e);
          chk(dr_last == (cnt == pw - 1), "R8 last flag", 32'(dr_last), 32'(cnt == pw - 1));
          cnt++;
        end
        if (dr_q_commit) begin
          chk(int'(dr_q_commit_words) == pw + 1, "R9 drain commit words",
              32'(dr_q_commit_words), 32'(pw + 1));
          chk(cnt == pw, "R8 drain word count", 32'(cnt), 32'(pw));
          chk_drop = 1;
        end
        if (!dr_req && !dr_q_commit) begin
          dr_ack = 1'b0;
          in_pkt = 0;
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit held;
    repeat (3) @(negedge clk);
    chk(!fl_ack && !fl_q_wr && !fl_q_commit, "R1 reset fill idle",
        {29'd0, fl_ack, fl_q_wr, fl_q_commit}, 0);
    chk(!dr_req && !dr_valid && !dr_q_rd && !dr_q_commit, "R7 reset drain idle",
        {28'd0, dr_req, dr_valid, dr_q_rd, dr_q_commit}, 0);
    rst_n = 1'b1;
    sink_en = 1'b1;

    // one packet in flight at a time, varied lengths and tails
    send_pkt(1, 0);
    send_pkt(4, 0);
    send_pkt(5, 1);
    send_pkt(8, 0);
    send_pkt(13, 1);
    send_pkt(0, 0);   // R6 header only
    send_pkt(3, 0);
    repeat (10) @(negedge clk);

    // fill the queue with the sink stalled
    sink_en = 1'b0;
    send_pkt(20, 0);
    send_pkt(20, 1);
    send_pkt(12, 0);  // R1 exact fit: 4 words into 4 free
    held = 1'b1;
    fork
      send_pkt(0, 0);
      begin
        repeat (20) begin
          @(negedge clk);
          if (fl_ack || fl_q_wr) held = 1'b0;
        end
        chk(held, "R1 ack withheld while full", 32'(!held), 0);
        sink_en = 1'b1;
      end
    join

    while (exp_ddata.size() != 0 || exp_dlen.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_wr.size() == 0 && exp_fc.size() == 0, "R4 all fill results seen",
        32'(exp_wr.size() + exp_fc.size()), 0);
    chk(!dr_req && occ == 0, "R9 drain idle and queue empty", 32'(occ), 0);
    summary();
    $finish;
  end
endmodule